// File: doc/BRIEF.md
# Serial I/Q Sample Serializer

This block takes parallel words from an upstream source over a valid/ready handshake and sends them out on one serial lane. The lane has three wires: a data bit, a framing strobe and a forwarded bit clock. In complex mode each accepted word is an I/Q pair. The I bits go out first and the Q bits follow, most significant bit first in both halves. In symbol mode only the I field is sent, as a real-valued word of 2, 8 or 16 bits. A 2-bit symbol travels in an 8-bit frame, and the padding after the two valid bits is zero.

The strobe has two shapes. In level shape it is high while I bits are on the line and low while Q bits are. In symbol mode it stays high for the whole word. In pulse shape it is high only on the first bit of each frame. Mode, symbol width and strobe shape are captured when a word is accepted. Changing them during a frame has no effect until the next frame. When a new word is waiting at the end of a frame it follows with no gap. With no word waiting, the data and strobe lines rest low.

The forwarded clock is the inverse of the bit clock. Its rising edge therefore falls in the middle of each bit, which gives the receiver a centred sampling point.

Top module: `iqSerTx`

## Requirements
- R1: While reset is held and right after it is released, serData and serStrobe are 0 and inReady is 1.
- R2: In complex mode (cfgSymbol=0) an accepted pair is sent as 2*SAMPLE_W bits: inI from MSB to LSB, then inQ from MSB to LSB. The first bit appears in the cycle after the handshake.
- R3: Level strobe (cfgPulse=0) in complex mode is 1 during the SAMPLE_W I bits and 0 during the SAMPLE_W Q bits.
- R4: Pulse strobe (cfgPulse=1) is 1 on the first bit of a frame and 0 on every other bit, in either mode.
- R5: In symbol mode (cfgSymbol=1) with cfgSymWidth=2 or 3, the frame is 16 bits: inI[15:0] MSB first. inQ does not appear.
- R6: In symbol mode with cfgSymWidth=1, the frame is 8 bits: inI[7:0] MSB first.
- R7: In symbol mode with cfgSymWidth=0, the frame is 8 bits: inI[1] and then inI[0], followed by six 0 bits. Higher bits of inI are not sent.
- R8: Level strobe in symbol mode is 1 for every bit of the frame.
- R9: inReady is 1 only when no frame is running or the last bit is on the line. A word accepted during the last bit starts in the next cycle, with no idle cycle in between.
- R10: When no frame is running, serData and serStrobe are 0.
- R11: cfgSymbol, cfgSymWidth and cfgPulse are captured only at the handshake. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream word available |
| inReady | output | 1 | Block can take a word this cycle |
| inI | input | SAMPLE_W | In-phase field, or the symbol |
| inQ | input | SAMPLE_W | Quadrature field, unused in symbol mode |
| cfgSymbol | input | 1 | 0 = complex I/Q pairs, 1 = real symbols |
| cfgSymWidth | input | 2 | Symbol width: 0 = 2 bits, 1 = 8 bits, 2 or 3 = 16 bits |
| cfgPulse | input | 1 | 0 = level strobe, 1 = one-bit pulse strobe |
| serData | output | 1 | Serial data bit |
| serStrobe | output | 1 | Frame strobe |
| serClk | output | 1 | Forwarded clock, inverse of clk |

## Verification
A word is accepted at a rising edge. Its first bit and first strobe value are due one edge later, and bit k is due k edges after that. The bench therefore samples on each falling edge that follows, starting at the first falling edge after the accepting rising edge, and builds the whole frame from those samples before comparing it with the value computed from the requirements. inReady is combinational from the frame state, so it is read on the same falling edge as the bit it belongs to. The idle check is due on the falling edge just after the last bit. The assertions use a one-cycle delay from the handshake for the first bit and strobe.

// File: rtl/iqser_pkg.sv
package iqser_pkg;

  // Strobes from the frame sequencer to the shift datapath.
  typedef struct packed {
    logic load;
    logic shift;
  } dpCtrl_t;

  // Symbol width codes; code 3 behaves like the 16-bit code.
  typedef enum logic [1:0] {
    SYM_W2  = 2'd0,
    SYM_W8  = 2'd1,
    SYM_W16 = 2'd2
  } symWidth_e;

  localparam int SYM_SHORT_FRAME = 8;
  localparam int SYM_LONG_FRAME  = 16;

endpackage

// File: rtl/iqser_ctrl.sv
module iqser_ctrl
  import iqser_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          cfgSymbol,
  input  logic [1:0]    cfgSymWidth,
  input  logic          cfgPulse,
  output logic          inReady,
  output logic          frameActive,
  output logic          frameStrobe,
  output logic          pulseLatched,
  output dpCtrl_t       dpCtrl
);

  localparam int PAIR_W = 2 * SAMPLE_W;
  localparam int CNT_W  = $clog2(PAIR_W);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             symLatched;
  logic [1:0]       widthLatched;
  logic             lastBit;
  logic             accept;

  // Index of the final bit for the configuration held by this frame.
  always_comb begin
    if (!symLatched) begin
      lastIdx = CNT_W'(PAIR_W - 1);
    end else begin
      case (widthLatched)
        SYM_W2, SYM_W8: lastIdx = CNT_W'(SYM_SHORT_FRAME - 1);
        default:        lastIdx = CNT_W'(SYM_LONG_FRAME - 1);
      endcase
    end
  end

  assign lastBit = frameActive && (bitCnt == lastIdx);
  assign inReady = !frameActive || lastBit;
  assign accept  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameActive  <= 1'b0;
      bitCnt       <= '0;
      symLatched   <= 1'b0;
      widthLatched <= 2'd0;
      pulseLatched <= 1'b0;
    end else if (accept) begin
      frameActive  <= 1'b1;
      bitCnt       <= '0;
      symLatched   <= cfgSymbol;
      widthLatched <= cfgSymWidth;
      pulseLatched <= cfgPulse;
    end else if (frameActive) begin
      if (lastBit) begin
        frameActive <= 1'b0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // Strobe shape from the latched settings and the bit position.
  always_comb begin
    if (!frameActive) begin
      frameStrobe = 1'b0;
    end else if (pulseLatched) begin
      frameStrobe = (bitCnt == '0);
    end else if (symLatched) begin
      frameStrobe = 1'b1;
    end else begin
      frameStrobe = (bitCnt < CNT_W'(SAMPLE_W));
    end
  end

  assign dpCtrl.load  = accept;
  assign dpCtrl.shift = frameActive;

endmodule

// File: rtl/iqser_dp.sv
module iqser_dp
  import iqser_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             dpCtrl,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  input  logic                cfgSymbol,
  input  logic [1:0]          cfgSymWidth,
  output logic                lineBit
);

  localparam int PAIR_W = 2 * SAMPLE_W;

  logic [PAIR_W-1:0] shReg;
  logic [PAIR_W-1:0] loadVal;

  // Left-align the payload so the first bit to send sits at the top.
  always_comb begin
    if (!cfgSymbol) begin
      loadVal = {inI, inQ};
    end else begin
      case (cfgSymWidth)
        SYM_W2:  loadVal = {inI[1:0], {(PAIR_W-2){1'b0}}};
        SYM_W8:  loadVal = {inI[7:0], {(PAIR_W-8){1'b0}}};
        default: loadVal = {inI[15:0], {(PAIR_W-16){1'b0}}};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (dpCtrl.load) begin
      shReg <= loadVal;
    end else if (dpCtrl.shift) begin
      shReg <= {shReg[PAIR_W-2:0], 1'b0};
    end
  end

  assign lineBit = shReg[PAIR_W-1];

endmodule

// File: rtl/iqSerTx.sv
module iqSerTx
  import iqser_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  input  logic                cfgSymbol,
  input  logic [1:0]          cfgSymWidth,
  input  logic                cfgPulse,
  output logic                serData,
  output logic                serStrobe,
  output logic                serClk
);

  dpCtrl_t dpCtrl;
  logic    frameActive;
  logic    pulseLatched;
  logic    lineBit;

  iqser_ctrl #(.SAMPLE_W(SAMPLE_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .cfgSymbol    (cfgSymbol),
    .cfgSymWidth  (cfgSymWidth),
    .cfgPulse     (cfgPulse),
    .inReady      (inReady),
    .frameActive  (frameActive),
    .frameStrobe  (serStrobe),
    .pulseLatched (pulseLatched),
    .dpCtrl       (dpCtrl)
  );

  iqser_dp #(.SAMPLE_W(SAMPLE_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .dpCtrl      (dpCtrl),
    .inI         (inI),
    .inQ         (inQ),
    .cfgSymbol   (cfgSymbol),
    .cfgSymWidth (cfgSymWidth),
    .lineBit     (lineBit)
  );

  assign serData = frameActive & lineBit;
  // Inverted bit clock puts the receiver's rising edge mid-bit.
  assign serClk  = ~clk;

endmodule

// File: rtl/iqSerTx_chk.sv
module iqSerTx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic [SAMPLE_W-1:0] inI,
  input logic                cfgSymbol,
  input logic                serData,
  input logic                serStrobe,
  input logic                pulseLatched
);

  // R2
  iq_first_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !cfgSymbol) |=> (serData == $past(inI[SAMPLE_W-1])));

  // R3
  first_bit_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> serStrobe);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseLatched && serStrobe) |=> !serStrobe);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> (!serData && !serStrobe));

endmodule

bind iqSerTx iqSerTx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inReady      (inReady),
  .inI          (inI),
  .cfgSymbol    (cfgSymbol),
  .serData      (serData),
  .serStrobe    (serStrobe),
  .pulseLatched (pulseLatched)
);

// File: tb/iqSerTx_tb_top.sv
module iqSerTx_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [W-1:0] inI = '0;
  logic [W-1:0] inQ = '0;
  logic         cfgSymbol = 1'b0;
  logic [1:0]   cfgSymWidth = 2'd0;
  logic         cfgPulse = 1'b0;
  logic         serData;
  logic         serStrobe;
  logic         serClk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iqSerTx #(.SAMPLE_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inI(inI), .inQ(inQ), .cfgSymbol(cfgSymbol), .cfgSymWidth(cfgSymWidth),
    .cfgPulse(cfgPulse), .serData(serData), .serStrobe(serStrobe), .serClk(serClk)
  );

  // {symbol, width[1:0], pulse, I[15:0], Q[15:0]}
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 2'd0, 1'b0, 16'hA5C3, 16'h1234},
    {1'b0, 2'd0, 1'b1, 16'h8001, 16'hFFFE},
    {1'b1, 2'd2, 1'b0, 16'hBEEF, 16'h5555},
    {1'b1, 2'd3, 1'b1, 16'h0F0F, 16'hAAAA},
    {1'b1, 2'd1, 1'b0, 16'h00C6, 16'hFFFF},
    {1'b1, 2'd1, 1'b1, 16'hFF39, 16'h0000},
    {1'b1, 2'd0, 1'b0, 16'hFFFE, 16'hFFFF},
    {1'b1, 2'd0, 1'b1, 16'h0001, 16'h0000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int frameLen(input bit sym, input logic [1:0] w);
    if (!sym) return 2 * W;
    if (w == 2'd0 || w == 2'd1) return 8;
    return 16;
  endfunction

  function automatic bit expBit(input bit sym, input logic [1:0] w,
                                input logic [15:0] i, input logic [15:0] q, input int k);
    if (!sym) return (k < W) ? i[W-1-k] : q[2*W-1-k];
    if (w == 2'd0) return (k < 2) ? i[1-k] : 1'b0;
    if (w == 2'd1) return i[7-k];
    return i[15-k];
  endfunction

  function automatic bit expStrobe(input bit sym, input bit pulse, input int k);
    if (pulse) return (k == 0);
    if (sym) return 1'b1;
    return (k < W);
  endfunction

  task automatic runFrame(input bit sym, input logic [1:0] w, input bit pulse,
                          input logic [15:0] i, input logic [15:0] q,
                          input bit midChange, input string tag);
    int len;
    logic [31:0] gotD, expD, gotS, expS;
    len = frameLen(sym, w);
    gotD = '0; expD = '0; gotS = '0; expS = '0;
    @(negedge clk);
    cfgSymbol = sym; cfgSymWidth = w; cfgPulse = pulse;
    inI = i; inQ = q; inValid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) inValid = 1'b0;
      if (k == 1 && midChange) begin
        cfgSymbol = ~sym; cfgSymWidth = ~w; cfgPulse = ~pulse; inI = ~i;
      end
      gotD = {gotD[30:0], serData};
      expD = {expD[30:0], expBit(sym, w, i, q, k)};
      gotS = {gotS[30:0], serStrobe};
      expS = {expS[30:0], expStrobe(sym, pulse, k)};
    end
    check(gotD == expD, {tag, " data"}, gotD, expD);
    check(gotS == expS, {tag, " strobe"}, gotS, expS);
    @(negedge clk);
    // R10: line idle after the frame, ready for a new word
    check({serData, serStrobe, inReady} == 3'b001, "R10 idle",
          {29'd0, serData, serStrobe, inReady}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] gotD, gotS;
    int readyEarly;
    bit readyLast;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: during reset
    check({serData, serStrobe, inReady} == 3'b001, "R1 in reset",
          {29'd0, serData, serStrobe, inReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    // R1: after release
    check({serData, serStrobe, inReady} == 3'b001, "R1 after reset",
          {29'd0, serData, serStrobe, inReady}, 32'd1);

    // Table walk: R2 R3 (complex), R4 (pulse), R5 R6 R7 (symbol sizes), R8 (symbol level)
    for (int v = 0; v < 8; v++) begin
      string tag;
      bit sym;
      logic [1:0] w;
      sym = VEC[v][35];
      w = VEC[v][34:33];
      if (!sym) tag = VEC[v][32] ? "R2/R4 complex pulse" : "R2/R3 complex level";
      else if (w == 2'd0) tag = VEC[v][32] ? "R7/R4 sym2" : "R7/R8 sym2";
      else if (w == 2'd1) tag = VEC[v][32] ? "R6/R4 sym8" : "R6/R8 sym8";
      else tag = VEC[v][32] ? "R5/R4 sym16" : "R5/R8 sym16";
      runFrame(sym, w, VEC[v][32], VEC[v][31:16], VEC[v][15:0], 1'b0, tag);
    end

    // R11: settings and inputs changed mid-frame leave the frame intact
    runFrame(1'b0, 2'd0, 1'b0, 16'hC33C, 16'h0FF0, 1'b1, "R11 complex");
    runFrame(1'b1, 2'd0, 1'b1, 16'h0002, 16'h0000, 1'b1, "R11 sym2");

    // R9: back-to-back 8-bit symbols, no gap, ready only on last bit
    gotD = '0; gotS = '0; readyEarly = 0; readyLast = 1'b0;
    @(negedge clk);
    cfgSymbol = 1'b1; cfgSymWidth = 2'd1; cfgPulse = 1'b0;
    inI = 16'h005A; inValid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 0) inI = 16'h00C3;
      if (k == 8) inValid = 1'b0;
      if (k < 7 && inReady) readyEarly++;
      if (k == 7) readyLast = inReady;
      gotD = {gotD[30:0], serData};
      gotS = {gotS[30:0], serStrobe};
    end
    check(gotD == 32'h00005AC3, "R9 back-to-back data", gotD, 32'h00005AC3);
    check(gotS == 32'h0000FFFF, "R8 back-to-back strobe", gotS, 32'h0000FFFF);
    check(readyEarly == 0, "R9 ready mid-frame", readyEarly, 0);
    check(readyLast == 1'b1, "R9 ready on last bit", {31'd0, readyLast}, 1);
    @(negedge clk);
    check({serData, serStrobe} == 2'b00, "R10 idle after burst",
          {30'd0, serData, serStrobe}, 0);

    // R10: no word offered for a while keeps the line low
    repeat (5) @(negedge clk);
    check({serData, serStrobe, inReady} == 3'b001, "R10 long idle",
          {29'd0, serData, serStrobe, inReady}, 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule